// File: doc/BRIEF.md
# Chip-Select and Wait-State Controller

This block sits between a CPU core and its external memory and peripheral bus. It compares the top byte of the 24-bit address against four programmable regions and drives one active-low chip select for the winning region. Each access is stretched by the wait count programmed for that region. If the region has wait-pin monitoring turned on, the access is stretched further for as long as the addressed device holds the active-low `wait_n` input low.

The core side works as a valid/ready pair. The core raises `cpu_mreq` with `cpu_rd` or `cpu_wr` and a stable `cpu_addr`, and holds all of them until `cpu_ready` is high for one cycle. Back-pressure is the wait count plus any extension from `wait_n`. A request seen during bus handover is held off until handover ends. If `cpu_mreq` stays high after `cpu_ready`, a new access starts after one idle cycle.

An external master requests the bus with `bus_req_n`. The block grants the bus only between accesses. While it is granted, the block keeps generating chip selects from the address the master drives on `ext_addr`, qualified by `ext_mreq`.

Top module: `cswait_ctrl`

## Requirements
- R1: After reset, all chip selects, `rd_n`, `wr_n` and `bus_ack_n` are high and `bus_oe` is high. Region 0 is enabled over bytes 0x00..0xFF with wait count 7 and monitoring on, so an access takes 8 cycles. Regions 1..3 are disabled.
- R2: A region hits when it is enabled and lo <= addr[23:16] <= hi. The lowest-numbered hitting region's `cs_n` bit goes low, and no other bit does. With no hit, all chip selects stay high and the access still completes with zero waits.
- R3: An access to a region with wait count N holds its chip select low for N+1 cycles. `cpu_ready` is high only in the last of them.
- R4: When monitoring is on, every cycle in which `wait_n` is low at the point where the programmed waits have run out adds one more cycle to the access.
- R5: When monitoring is off, `wait_n` has no effect on access length.
- R6: During a read access `rd_n` is low and `wr_n` high. During a write the opposite holds. Outside accesses both are high.
- R7: A low `bus_req_n` during an access is not granted until the access completes. From idle, `bus_ack_n` goes low on the cycle after `bus_req_n` is seen low.
- R8: While `bus_ack_n` is low: `bus_oe` is low; `rd_n` and `wr_n` are high; `cpu_ready` stays low; `cs_n` is decoded from `ext_addr[23:16]` whenever `ext_mreq` is high.
- R9: `bus_ack_n` returns high on the cycle after `bus_req_n` is seen high.
- R10: Configuration writes are ignored while `bus_ack_n` is low.
- R11: Configuration writes select a region with `cfg_region` and a field with `cfg_field`: 0 = lower bound, 1 = upper bound, 2 = control, 3 = ignored. The control byte holds bit0 = enable, bit1 = monitoring, bits4:2 = wait count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 24 | Core address |
| cpu_mreq | input | 1 | Core memory request (valid) |
| cpu_rd | input | 1 | Core read strobe |
| cpu_wr | input | 1 | Core write strobe |
| cpu_ready | output | 1 | Access complete (ready) |
| wait_n | input | 1 | Active-low wait from device |
| bus_req_n | input | 1 | Active-low bus request |
| bus_ack_n | output | 1 | Active-low bus grant |
| bus_oe | output | 1 | High while the core side drives address/data |
| ext_addr | input | 24 | Address from external master |
| ext_mreq | input | 1 | External master memory request |
| cs_n | output | 4 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_region | input | 2 | Region being written |
| cfg_field | input | 2 | Field being written |
| cfg_wdata | input | 8 | Configuration data |

## Verification
The hardest situation to reach is a bus request that lands in the middle of a long, wait-stretched access. The access must finish before the grant appears. The stimulus forks an access to a region with five waits and drops `bus_req_n` two cycles into it. It then checks that `bus_ack_n` stays high through the final cycle and falls only after an idle cycle. While the bus is granted, the bench tries a configuration write and holds a pending core request. It then confirms that the write had no effect, by timing a later access to the same region, and that the held request runs only after release.

// File: rtl/cswait_pkg.sv
package cswait_pkg;
  localparam int BOUND_W = 8;
  localparam int WCNT_W  = 3;

  typedef struct packed {
    logic [BOUND_W-1:0] lo;
    logic [BOUND_W-1:0] hi;
    logic               en;
    logic               mon;
    logic [WCNT_W-1:0]  wcnt;
  } region_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_GRANT} bus_state_e;

  localparam logic [1:0] FLD_LO   = 2'd0;
  localparam logic [1:0] FLD_HI   = 2'd1;
  localparam logic [1:0] FLD_CTRL = 2'd2;
endpackage

// File: rtl/cswait_regs.sv
module cswait_regs
  import cswait_pkg::*;
#(
  parameter int NREG = 4,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_region,
  input  logic [1:0]             cfg_field,
  input  logic [7:0]             cfg_wdata,
  input  logic                   lock,
  output region_cfg_t [NREG-1:0] cfg_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam region_cfg_t RST_VAL = (g == 0) ?
      region_cfg_t'{lo: '0, hi: '1, en: 1'b1, mon: 1'b1, wcnt: '1} :
      region_cfg_t'{lo: '0, hi: '0, en: 1'b0, mon: 1'b0, wcnt: '0};
    logic hit_w;
    assign hit_w = cfg_we && !lock && (cfg_region == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[g] <= RST_VAL;
      end else if (hit_w) begin
        case (cfg_field)
          FLD_LO:   cfg_o[g].lo <= cfg_wdata;
          FLD_HI:   cfg_o[g].hi <= cfg_wdata;
          FLD_CTRL: begin
            cfg_o[g].en   <= cfg_wdata[0];
            cfg_o[g].mon  <= cfg_wdata[1];
            cfg_o[g].wcnt <= cfg_wdata[2+:WCNT_W];
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && cfg_we) |=> $stable(cfg_o));
endmodule

// File: rtl/cswait_decode.sv
module cswait_decode
  import cswait_pkg::*;
#(
  parameter int NREG = 4,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [BOUND_W-1:0]     addr_hi,
  input  region_cfg_t [NREG-1:0] cfg,
  output logic                   hit,
  output logic [SEL_W-1:0]       idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (cfg[i].en && addr_hi >= cfg[i].lo && addr_hi <= cfg[i].hi) begin
        hit = 1'b1;
        idx = SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/cswait_seq.sv
module cswait_seq
  import cswait_pkg::*;
#(
  parameter int NREG = 4,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              start_rd,
  input  logic              req_bus,
  input  logic              wait_n,
  input  logic              dec_hit,
  input  logic [SEL_W-1:0]  dec_idx,
  input  logic [WCNT_W-1:0] dec_wcnt,
  input  logic              dec_mon,
  output bus_state_e        state,
  output logic              cur_hit,
  output logic [SEL_W-1:0]  cur_idx,
  output logic              cur_rd,
  output logic              cpu_ready
);
  logic [WCNT_W-1:0] left_q;
  logic              mon_q;
  logic              stretch;

  assign stretch   = mon_q && !wait_n;
  assign cpu_ready = (state == ST_ACC) && (left_q == '0) && !stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      left_q  <= '0;
      mon_q   <= 1'b0;
      cur_hit <= 1'b0;
      cur_idx <= '0;
      cur_rd  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_bus) begin
            state <= ST_GRANT;
          end else if (start_req) begin
            state   <= ST_ACC;
            cur_hit <= dec_hit;
            cur_idx <= dec_idx;
            cur_rd  <= start_rd;
            left_q  <= dec_hit ? dec_wcnt : '0;
            mon_q   <= dec_hit && dec_mon;
          end
        end
        ST_ACC: begin
          if (left_q != '0) left_q <= left_q - 1'b1;
          else if (!stretch) state <= ST_IDLE;
        end
        ST_GRANT: if (!req_bus) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC && left_q == '0 && mon_q && !wait_n) |=> (state == ST_ACC && left_q == '0));
  // R3
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R7
  grant_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACC) |=> (state != ST_GRANT));
endmodule

// File: rtl/cswait_ctrl.sv
module cswait_ctrl
  import cswait_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int ADDR_W = 24,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_mreq,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              cpu_ready,
  input  logic              wait_n,
  input  logic              bus_req_n,
  output logic              bus_ack_n,
  output logic              bus_oe,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_mreq,
  output logic [NREG-1:0]   cs_n,
  output logic              rd_n,
  output logic              wr_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_region,
  input  logic [1:0]        cfg_field,
  input  logic [7:0]        cfg_wdata
);
  region_cfg_t [NREG-1:0] cfg;
  bus_state_e             state;
  logic                   granted;
  logic [BOUND_W-1:0]     dec_addr;
  logic                   dec_hit, cur_hit, cur_rd;
  logic [SEL_W-1:0]       dec_idx, cur_idx;

  assign granted  = (state == ST_GRANT);
  assign dec_addr = granted ? ext_addr[ADDR_W-1 -: BOUND_W] : cpu_addr[ADDR_W-1 -: BOUND_W];

  cswait_regs #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .lock(granted), .cfg_o(cfg)
  );

  cswait_decode #(.NREG(NREG)) u_dec (
    .addr_hi(dec_addr), .cfg(cfg), .hit(dec_hit), .idx(dec_idx)
  );

  cswait_seq #(.NREG(NREG)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_req(cpu_mreq && (cpu_rd || cpu_wr)), .start_rd(cpu_rd),
    .req_bus(!bus_req_n), .wait_n(wait_n),
    .dec_hit(dec_hit), .dec_idx(dec_idx),
    .dec_wcnt(cfg[dec_idx].wcnt), .dec_mon(cfg[dec_idx].mon),
    .state(state), .cur_hit(cur_hit), .cur_idx(cur_idx), .cur_rd(cur_rd),
    .cpu_ready(cpu_ready)
  );

  always_comb begin
    cs_n = '1;
    if (state == ST_ACC && cur_hit) cs_n[cur_idx] = 1'b0;
    else if (granted && ext_mreq && dec_hit) cs_n[dec_idx] = 1'b0;
  end

  assign rd_n      = !(state == ST_ACC && cur_rd);
  assign wr_n      = !(state == ST_ACC && !cur_rd);
  assign bus_ack_n = !granted;
  assign bus_oe    = !granted;

  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> (rd_n && wr_n && !bus_oe && !cpu_ready));
  // R7
  ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> ($past(!bus_req_n) && $past(rd_n && wr_n)));
  // R9
  ack_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_n) |-> $past(bus_req_n));
endmodule

// File: tb/cswait_ctrl_tb.sv
module cswait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0, ext_addr = '0;
  logic        cpu_mreq = 0, cpu_rd = 0, cpu_wr = 0, wait_n = 1, bus_req_n = 1, ext_mreq = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_region = '0, cfg_field = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cpu_ready, bus_ack_n, bus_oe, rd_n, wr_n;
  logic [3:0]  cs_n;

  int checks = 0, errors = 0;
  bit chk_on = 0;

  always #4 clk = ~clk;

  cswait_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_ready(cpu_ready), .wait_n(wait_n), .bus_req_n(bus_req_n),
    .bus_ack_n(bus_ack_n), .bus_oe(bus_oe), .ext_addr(ext_addr), .ext_mreq(ext_mreq),
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cfg_we(cfg_we), .cfg_region(cfg_region),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata)
  );

  // behavioural reference: 0 idle, 1 access, 2 granted
  int m_mode, m_left, m_idx, m_mon, m_rd;
  int m_lo[4], m_hi[4], m_en[4], m_mn[4], m_w[4];

  function automatic int mdec(input logic [7:0] a);
    for (int i = 0; i < 4; i++)
      if (m_en[i] != 0 && int'(a) >= m_lo[i] && int'(a) <= m_hi[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_idx = -1; m_mon = 0; m_rd = 0;
      for (int i = 0; i < 4; i++) begin
        m_lo[i] = 0; m_hi[i] = (i == 0) ? 255 : 0; m_en[i] = (i == 0) ? 1 : 0;
        m_mn[i] = (i == 0) ? 1 : 0; m_w[i] = (i == 0) ? 7 : 0;
      end
    end else begin
      bit locked;
      locked = (m_mode == 2);
      case (m_mode)
        0: if (!bus_req_n) m_mode = 2;
           else if (cpu_mreq && (cpu_rd || cpu_wr)) begin
             m_idx = mdec(cpu_addr[23:16]);
             m_left = (m_idx >= 0) ? m_w[m_idx] : 0;
             m_mon = (m_idx >= 0) ? m_mn[m_idx] : 0;
             m_rd = cpu_rd; m_mode = 1;
           end
        1: if (m_left > 0) m_left--;
           else if (!(m_mon != 0 && !wait_n)) m_mode = 0;
        default: if (bus_req_n) m_mode = 0;
      endcase
      if (cfg_we && !locked) begin
        case (cfg_field)
          2'd0: m_lo[cfg_region] = int'(cfg_wdata);
          2'd1: m_hi[cfg_region] = int'(cfg_wdata);
          2'd2: begin
            m_en[cfg_region] = int'(cfg_wdata[0]);
            m_mn[cfg_region] = int'(cfg_wdata[1]);
            m_w[cfg_region]  = int'(cfg_wdata[4:2]);
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      int e;
      logic [3:0] ecs;
      #1;
      e = -1;
      if (m_mode == 1) e = m_idx;
      else if (m_mode == 2 && ext_mreq) e = mdec(ext_addr[23:16]);
      ecs = 4'hF;
      if (e >= 0) ecs[e] = 1'b0;
      chk("R2 cs_n", int'(cs_n), int'(ecs));
      chk("R3 cpu_ready", int'(cpu_ready),
          int'(m_mode == 1 && m_left == 0 && !(m_mon != 0 && !wait_n)));
      chk("R6 rd_n", int'(rd_n), int'(!(m_mode == 1 && m_rd != 0)));
      chk("R6 wr_n", int'(wr_n), int'(!(m_mode == 1 && m_rd == 0)));
      chk("R7 bus_ack_n", int'(bus_ack_n), int'(m_mode != 2));
      chk("R8 bus_oe", int'(bus_oe), int'(m_mode != 2));
    end
  end

  task automatic cfg_wr(input int reg_i, input int fld, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_region = 2'(reg_i); cfg_field = 2'(fld); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input logic [23:0] a, input bit rd, input int rel,
                     input int exp_len, input logic [3:0] exp_cs, input string r);
    int cyc;
    @(negedge clk);
    cpu_addr = a; cpu_rd = rd; cpu_wr = !rd; cpu_mreq = 1;
    wait_n = (rel > 0) ? 1'b0 : 1'b1;
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == rel) wait_n = 1;
      #1;
      if (cyc == 1) chk({r, " R2 select"}, int'(cs_n), int'(exp_cs));
      if (cpu_ready) break;
    end
    chk({r, " length"}, cyc, exp_len);
    @(negedge clk);
    cpu_mreq = 0; cpu_rd = 0; cpu_wr = 0; wait_n = 1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 cs_n reset", int'(cs_n), 'hF);
    chk("R1 strobes reset", int'({rd_n, wr_n, bus_ack_n, bus_oe}), 'hF);
    chk_on = 1;
    // R1: default region 0 with 7 waits
    acc(24'h123456, 1, 0, 8, 4'b1110, "R1 default");
    // R11: program regions
    cfg_wr(0, 1, 'h0F); cfg_wr(0, 2, 'b00111);           // r0 0x00-0x0F, w1, mon
    cfg_wr(1, 0, 'h10); cfg_wr(1, 1, 'h1F); cfg_wr(1, 2, 'b01011); // w2 mon
    cfg_wr(2, 0, 'h18); cfg_wr(2, 1, 'h30); cfg_wr(2, 2, 'b00001); // w0 no mon
    cfg_wr(3, 0, 'h80); cfg_wr(3, 1, 'h8F); cfg_wr(3, 2, 'b10111); // w5 mon
    cfg_wr(3, 3, 'h00);                                   // R11 field 3 ignored
    acc(24'h050000, 1, 0, 2, 4'b1110, "R3 r0 w1");
    acc(24'h150000, 1, 0, 3, 4'b1101, "R3 r1 w2");
    acc(24'h1A0000, 1, 0, 3, 4'b1101, "R2 overlap priority");
    acc(24'h250000, 1, 0, 1, 4'b1011, "R3 r2 w0");
    acc(24'h400000, 1, 0, 1, 4'b1111, "R2 unmapped");
    acc(24'h820000, 0, 0, 6, 4'b0111, "R6 write r3");
    // wait pin
    acc(24'h150000, 1, 6, 6, 4'b1101, "R4 stretch");
    acc(24'h250000, 1, 5, 1, 4'b1011, "R5 no monitor");
    acc(24'h050000, 1, 1, 2, 4'b1110, "R4 early release");
    acc(24'h8F0000, 0, 9, 9, 4'b0111, "R4 long stretch");
    // bus request in mid-access
    fork
      acc(24'h820000, 1, 0, 6, 4'b0111, "R7 access before grant");
      begin repeat (2) @(negedge clk); bus_req_n = 0; end
    join
    #1;
    chk("R7 no grant yet", int'(bus_ack_n), 1);
    @(negedge clk); #1;
    chk("R7 granted", int'(bus_ack_n), 0);
    chk("R8 bus released", int'(bus_oe), 0);
    @(negedge clk);
    ext_addr = 24'h1A0000; ext_mreq = 1;
    #1 chk("R8 ext decode", int'(cs_n), 'b1101);
    @(negedge clk);
    ext_addr = 24'h900000;
    #1 chk("R8 ext unmapped", int'(cs_n), 'hF);
    cfg_wr(3, 2, 'h00);                                   // R10 must be ignored
    @(negedge clk);
    ext_mreq = 0;
    cpu_addr = 24'h250000; cpu_rd = 1; cpu_mreq = 1;
    @(negedge clk); #1;
    chk("R8 core held", int'(cpu_ready), 0);
    @(negedge clk);
    bus_req_n = 1;
    #1 chk("R9 ack still low", int'(bus_ack_n), 0);
    @(negedge clk); #1;
    chk("R9 ack released", int'(bus_ack_n), 1);
    @(negedge clk); #1;
    chk("R8 held request runs", int'(cpu_ready), 1);
    @(negedge clk);
    cpu_mreq = 0; cpu_rd = 0;
    acc(24'h820000, 0, 0, 6, 4'b0111, "R10 cfg unchanged");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule